// File: doc/BRIEF.md
# Retained Event Counter Bank

This block keeps a small bank of 24-bit event counters that advance on already-debounced, single-cycle event strobes. The counters and their control state are built to survive an ordinary system reset: a general reset from any source leaves every counter, flag and enable as it was. Only two things clear them. Software can write the mode register, which stores a new run bit and rate field and wipes all other state. A separate power-loss reset models the collapse of the retention supply.

Each time the counters are cleared, and each time a system reset arrives, counting is held off for a short fixed window. This stands in for the time the hardware needs to synchronise across clock domains. Each counter raises an event flag on every accepted event and an overflow flag when it wraps. The flags are cleared by writing ones. They feed one interrupt line through per-source enables and a global enable.

Top module: `evtcnt_bank`

## Requirements
- R1: Counter i advances by exactly one on each clock edge where evt_in[i] is high, the run bit (mode register bit 0) is 1 and no blackout is active. With the run bit at 0, events leave the counters unchanged.
- R2: A counter at 0xFFFFFF that accepts an event wraps to 0 and sets its overflow flag (flag bit NUM_CNT+i). Every accepted event on counter i sets its event flag (flag bit i).
- R3: Asserting sys_rst changes none of the counters, the mode register, the enables or the flags.
- R4: A write to address 0 stores wdata[7:0] as the mode register. The same write clears all counters, all flags, the source enables and the global enable, and an event on that same edge is not counted.
- R5: After a mode-register write, a sys_rst edge or the release of pwr_rst, events on the next BLACKOUT (default 2) clock edges are not counted.
- R6: Writing address 2 clears each flag whose wdata bit is 1. A flag whose event happens on the same edge stays set.
- R7: irq is 1 exactly when the global enable (address 3 bit 0) is 1 and some flag is set whose matching enable bit (address 1) is also 1.
- R8: While pwr_rst is high, every counter, flag, enable and the mode register become 0.
- R9: A write to address 4+i loads wdata[23:0] into counter i. The load wins over an event on the same edge, and it raises no overflow.
- R10: reg_rdata returns the following: the mode byte at address 0, the enables at 1, the flags at 2, the global enable at 3, and counter i zero-extended at 4+i. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | General system reset; starts a blackout only |
| pwr_rst | input | 1 | Retention-loss reset, synchronous, clears all |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_in | input | NUM_CNT | Debounced event strobes, one per counter |
| irq | output | 1 | Combined interrupt |

## Verification
The counters are driven with several kinds of event traffic:
- steady strobes on one channel at a time, which separate the channels from each other;
- strobes on both channels at once, which expose shared-path mistakes;
- strobes that land inside each blackout window, which show whether suppression lasts the right number of edges;
- a pseudo-random mix that also includes system resets and flag-clear writes.

Strobes that coincide with a mode write, a counter load or a flag clear settle the priority rules. Loading a value near the top of the range exercises the wrap. After every edge, the interrupt line is compared with a behavioural model, and the registers are read back through the bus.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_MODE = 4'd0;
    localparam logic [ADDR_W-1:0] A_IEN  = 4'd1;
    localparam logic [ADDR_W-1:0] A_FLAG = 4'd2;
    localparam logic [ADDR_W-1:0] A_GEN  = 4'd3;
    localparam logic [ADDR_W-1:0] A_CNT0 = 4'd4;

    typedef struct packed {
        logic [3:0] rate;
        logic [2:0] spare;
        logic       run;
    } mode_t;

    typedef struct packed {
        logic clr;
        logic load;
        logic inc;
    } cnt_ctl_t;

    function automatic logic hits_cnt(input logic [ADDR_W-1:0] a, input int idx);
        return int'(a) == int'(A_CNT0) + idx;
    endfunction

endpackage

// File: rtl/evtcnt_blackout.sv
module evtcnt_blackout #(
    parameter int unsigned BLK = 2
) (
    input  logic clk,
    input  logic pwr_rst,
    input  logic restart,
    output logic busy
);
    localparam int unsigned W = $clog2(BLK + 1);

    logic [W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (pwr_rst || restart)
            tmr <= W'(BLK);
        else if (tmr != '0)
            tmr <= tmr - 1'b1;
    end

    assign busy = (tmr != '0);

    // R5
    restart_arms_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        restart |=> busy);

    // R5
    no_spurious_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        (!restart && !busy) |=> !busy);

endmodule

// File: rtl/evtcnt_slice.sv
module evtcnt_slice
    import evtcnt_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             pwr_rst,
    input  cnt_ctl_t         ctl,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr_evt,
    input  logic             clr_ovf,
    output logic [CNT_W-1:0] cnt,
    output logic             evt_flag,
    output logic             ovf_flag
);
    logic wrap;
    assign wrap = ctl.inc && !ctl.load && (cnt == '1);

    always_ff @(posedge clk) begin
        if (pwr_rst || ctl.clr) begin
            cnt      <= '0;
            evt_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (ctl.load)
                cnt <= load_val;
            else if (ctl.inc)
                cnt <= cnt + 1'b1;
            evt_flag <= (evt_flag & ~clr_evt) | ctl.inc;
            ovf_flag <= (ovf_flag & ~clr_ovf) | wrap;
        end
    end

    // R1
    step_one_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        (ctl.inc && !ctl.load && !ctl.clr) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        (!ctl.inc && !ctl.load && !ctl.clr) |=> $stable(cnt));

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        (ctl.inc && !ctl.load && !ctl.clr && cnt == '1) |=> (ovf_flag && cnt == '0));

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        ctl.clr |=> (cnt == '0 && !evt_flag && !ovf_flag));

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        (ctl.inc && !ctl.clr) |=> evt_flag);

endmodule

// File: rtl/evtcnt_irq.sv
module evtcnt_irq #(
    parameter int unsigned NSRC = 4
) (
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] ien,
    input  logic            gen,
    output logic            irq
);
    assign irq = gen & (|(flags & ien));
endmodule

// File: rtl/evtcnt_bank.sv
module evtcnt_bank
    import evtcnt_pkg::*;
#(
    parameter int unsigned NUM_CNT  = 2,
    parameter int unsigned CNT_W    = 24,
    parameter int unsigned BLACKOUT = 2
) (
    input  logic               clk,
    input  logic               sys_rst,
    input  logic               pwr_rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_CNT-1:0] evt_in,
    output logic               irq
);
    localparam int unsigned NSRC = 2 * NUM_CNT;

    mode_t                mode_q;
    logic [NSRC-1:0]      ien_q;
    logic                 gen_q;
    logic [NSRC-1:0]      flags;
    logic [NSRC-1:0]      flag_clr;
    logic                 mode_wr;
    logic                 busy;
    logic                 count_ok;
    logic [CNT_W-1:0]     cnt_arr [NUM_CNT];
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;
    logic                 unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign mode_wr  = reg_wr && (reg_addr == A_MODE);
    assign flag_clr = (reg_wr && reg_addr == A_FLAG) ? reg_wdata[NSRC-1:0] : '0;
    assign count_ok = mode_q.run && !busy;

    always_ff @(posedge clk) begin
        if (pwr_rst) begin
            mode_q <= '0;
            ien_q  <= '0;
            gen_q  <= 1'b0;
        end else if (mode_wr) begin
            mode_q <= mode_t'(reg_wdata[7:0]);
            ien_q  <= '0;
            gen_q  <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_IEN) ien_q <= reg_wdata[NSRC-1:0];
            if (reg_addr == A_GEN) gen_q <= reg_wdata[0];
        end
    end

    evtcnt_blackout #(.BLK(BLACKOUT)) u_blk (
        .clk     (clk),
        .pwr_rst (pwr_rst),
        .restart (mode_wr | sys_rst),
        .busy    (busy)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        cnt_ctl_t ctl;
        assign ctl.clr  = mode_wr;
        assign ctl.load = reg_wr && hits_cnt(reg_addr, g);
        assign ctl.inc  = evt_in[g] && count_ok;

        evtcnt_slice #(.CNT_W(CNT_W)) u_slice (
            .clk      (clk),
            .pwr_rst  (pwr_rst),
            .ctl      (ctl),
            .load_val (reg_wdata[CNT_W-1:0]),
            .clr_evt  (flag_clr[g]),
            .clr_ovf  (flag_clr[NUM_CNT+g]),
            .cnt      (cnt_arr[g]),
            .evt_flag (flags[g]),
            .ovf_flag (flags[NUM_CNT+g])
        );
        assign cnt_flat[g*CNT_W +: CNT_W] = cnt_arr[g];
    end

    evtcnt_irq #(.NSRC(NSRC)) u_irq (
        .flags (flags),
        .ien   (ien_q),
        .gen   (gen_q),
        .irq   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_MODE: reg_rdata = DATA_W'(mode_q);
            A_IEN:  reg_rdata = DATA_W'(ien_q);
            A_FLAG: reg_rdata = DATA_W'(flags);
            A_GEN:  reg_rdata = DATA_W'(gen_q);
            default: begin
                for (int i = 0; i < int'(NUM_CNT); i++)
                    if (hits_cnt(reg_addr, i)) reg_rdata[CNT_W-1:0] = cnt_arr[i];
            end
        endcase
    end

    // R3
    sysrst_keep_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        (sys_rst && !reg_wr) |=> ($stable(mode_q) && $stable(ien_q) && $stable(gen_q)));

    // R5
    blackout_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        (busy && !reg_wr) |=> $stable(cnt_flat));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        ((flags & ien_q) == '0 || !gen_q) |-> !irq);

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (pwr_rst)
        (gen_q && (flags & ien_q) != '0) |-> irq);

    // R8
    power_clear_chk: assert property (@(posedge clk)
        pwr_rst |=> (cnt_flat == '0 && flags == '0 && mode_q == '0 && ien_q == '0 && !gen_q));

endmodule

// File: tb/evtcnt_bank_bench.sv
`timescale 1ns/1ps
module evtcnt_bank_bench;
    localparam int NUM_CNT = 2;
    localparam int NSRC    = 2 * NUM_CNT;
    localparam int BLK     = 2;
    localparam int CMAX    = 24'hFFFFFF;

    logic        clk = 1'b0;
    logic        sys_rst = 1'b0;
    logic        pwr_rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NUM_CNT-1:0] evt_in = '0;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    int mcnt [NUM_CNT];
    int mflag, mien, mgen, mmode, mblk;

    always #2.5 clk = ~clk;

    evtcnt_bank u_evtcnt_bank (
        .clk(clk), .sys_rst(sys_rst), .pwr_rst(pwr_rst), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_in(evt_in), .irq(irq)
    );

    function automatic int mread(input int a);
        case (a)
            0: return mmode;
            1: return mien;
            2: return mflag;
            3: return mgen;
            default: return (a >= 4 && a < 4 + NUM_CNT) ? mcnt[a-4] : 0;
        endcase
    endfunction

    task automatic model(input bit pr, input bit sr, input bit wr, input int a,
                         input int wd, input int ev);
        if (pr) begin
            for (int i = 0; i < NUM_CNT; i++) mcnt[i] = 0;
            mflag = 0; mien = 0; mgen = 0; mmode = 0; mblk = BLK;
        end else if (wr && a == 0) begin
            for (int i = 0; i < NUM_CNT; i++) mcnt[i] = 0;
            mflag = 0; mien = 0; mgen = 0; mmode = wd & 'hFF; mblk = BLK;
        end else begin
            int newf = 0;
            bit ok = (mmode & 1) && (mblk == 0);
            for (int i = 0; i < NUM_CNT; i++) begin
                bit hit = ok && ev[i];
                if (hit) newf |= (1 << i);
                if (wr && a == 4 + i) mcnt[i] = wd & CMAX;
                else if (hit) begin
                    if (mcnt[i] == CMAX) begin
                        mcnt[i] = 0;
                        newf |= (1 << (NUM_CNT + i));
                    end else mcnt[i] = mcnt[i] + 1;
                end
            end
            if (wr && a == 1) mien = wd & ((1 << NSRC) - 1);
            if (wr && a == 3) mgen = wd & 1;
            mflag = (mflag & ~((wr && a == 2) ? wd : 0)) | newf;
            if (sr) mblk = BLK;
            else if (mblk > 0) mblk--;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit pr, input bit sr, input bit wr, input int a,
                       input int wd, input int ev, input string tag);
        pwr_rst = pr; sys_rst = sr; reg_wr = wr; reg_addr = a[3:0];
        reg_wdata = wd; evt_in = ev[NUM_CNT-1:0];
        @(posedge clk);
        model(pr, sr, wr, a, wd, ev);
        @(negedge clk);
        begin
            int e = (mgen != 0 && (mflag & mien) != 0) ? 1 : 0;
            chk(int'(irq) == e, {tag, " irq (R7)"}, int'(irq), e);
        end
    endtask

    task automatic rd(input int a, input string tag);
        cyc(0, 0, 0, a, 0, 0, tag);
        chk(int'(reg_rdata) == mread(a), {tag, " readback"}, int'(reg_rdata), mread(a));
    endtask

    task automatic rd_all(input string tag);
        for (int a = 0; a < 4 + NUM_CNT + 1; a++) rd(a, tag);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        @(negedge clk);
        for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, 0, 3, "R8");
        rd_all("R8");
        // mode write with coincident event: not counted
        cyc(0, 0, 1, 0, 'h51, 3, "R4");
        cyc(0, 0, 0, 4, 0, 3, "R5");
        cyc(0, 0, 0, 4, 0, 3, "R5");
        rd(4, "R5 blackout");
        rd(5, "R5 blackout");
        for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 0, 1, "R1");
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, 2, "R1");
        cyc(0, 0, 0, 0, 0, 3, "R1");
        rd_all("R1");
        rd(9, "R10 unmapped");
        cyc(0, 0, 1, 1, 'hF, 0, "R7");
        cyc(0, 0, 1, 3, 1, 0, "R7");
        cyc(0, 0, 0, 0, 0, 1, "R7");
        // clear with coincident event keeps flag
        cyc(0, 0, 1, 2, 1, 1, "R6");
        rd(2, "R6 set wins");
        cyc(0, 0, 1, 2, 'hF, 0, "R6");
        rd(2, "R6 cleared");
        cyc(0, 0, 1, 3, 0, 0, "R7");
        cyc(0, 0, 0, 0, 0, 1, "R7 masked");
        cyc(0, 0, 1, 3, 1, 0, "R7 unmasked");
        // overflow
        cyc(0, 0, 1, 5, 'hFFFFFE, 0, "R9");
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, 2, "R2");
        rd(5, "R2 wrap");
        rd(2, "R2 flags");
        cyc(0, 0, 1, 5, 'h10, 2, "R9");
        rd(5, "R9 load wins");
        cyc(0, 0, 1, 4, 'hFFFFFF, 0, "R9");
        cyc(0, 0, 0, 0, 0, 1, "R2");
        rd(4, "R2 wrap ch0");
        // system reset keeps state, starts blackout
        cyc(0, 1, 0, 0, 0, 3, "R3");
        cyc(0, 1, 0, 0, 0, 3, "R3");
        cyc(0, 0, 0, 0, 0, 3, "R5");
        rd_all("R3");
        // stopped mode
        cyc(0, 0, 1, 0, 'hA0, 0, "R4");
        rd_all("R4");
        for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, 0, 3, "R1");
        rd(4, "R1 stopped");
        rd(5, "R1 stopped");
        // mixed traffic
        cyc(0, 0, 1, 0, 'h31, 0, "R4");
        cyc(0, 0, 1, 1, 'hF, 0, "R7");
        cyc(0, 0, 1, 3, 1, 0, "R7");
        lfsr = 8'h5B;
        for (int k = 0; k < 400; k++) begin
            bit sr = (lfsr[7:4] == 4'h3);
            bit wr = (lfsr[3:1] == 3'h5);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc(0, sr, wr, 2, int'(lfsr[3:0]), int'(lfsr[1:0]), "R1 mix");
        end
        rd_all("R1 mix");
        cyc(1, 0, 0, 0, 0, 3, "R8");
        rd_all("R8 final");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule